// File: doc/BRIEF.md
# GPIO Port with Atomic Bit Set/Reset

A sixteen-pin general-purpose I/O port on a plain 32-bit memory-mapped register bus. Each cycle the bus presents a valid strobe, a write flag, a byte address and write data, and it gets read data back in the same cycle. Software gives each pin a 2-bit mode, drives the output latch either by writing it whole or through a write-only set/clear word, and reads the pin levels through a two-flop synchronizer.

The set/clear word lets several agents change individual pins without a read-modify-write race. The low half-word raises pins and the high half-word lowers them, and both take effect in one write. A clock-enable input gates the port: while it is low the bus cannot change any register, but reads still work. Each pin's output-enable is raised only when its mode selects general-purpose output.

Top module: `gpio_port`

## Requirements
- R1: After reset the mode register reads 0, every pin is an input, pin_oe_o is 0, and the output latch and pin_out_o are 0.
- R2: The mode register sits at offset 0x00, and pin N's field occupies bits 2N+1:2N. The codes are 00 input, 01 general output, 10 alternate, 11 analog. pin_oe_o[N] is 1 only when pin N's field is 01.
- R3: The output latch sits at offset 0x0C. It is written directly from wdata[15:0] and read back in bits 15:0 with bits 31:16 as 0, and pin_out_o always shows its value.
- R4: A write to the set/clear word at offset 0x18 with bit N (0..15) set to 1 drives latch bit N high one clock later.
- R5: A write to offset 0x18 with bit N+16 set to 1 drives latch bit N low. A pin whose bits N and N+16 are both 0 keeps its value.
- R6: When one write to offset 0x18 sets both bit N and bit N+16, pin N goes high.
- R7: While clk_en_i is 0, writes to any offset leave the mode register and the output latch unchanged.
- R8: The input data word at offset 0x14 shows pin_in_i in bits 15:0 (bits 31:16 read 0) through two flops. A change made before one clock edge is not visible after that edge, but is visible after the next. Writes to 0x14 have no effect.
- R9: Reads of offset 0x18 and of every unmapped word offset return 0.
- R10: bus_rdata_o is valid in the same cycle as a read (bus_valid_i=1, bus_write_i=0) and is 0 whenever no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Port enable; writes are ignored while low |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| pin_in_i | input | 16 | Asynchronous pin levels |
| pin_out_o | output | 16 | Output latch value to pads |
| pin_oe_o | output | 16 | Per-pin output enable |

## Verification
The assertions assume that reset is held for at least one edge. They also assume that bus inputs are stable around the rising edge, and that at least two clock edges pass after reset before the synchronizer check begins, which a saturating age counter enforces. The bench changes all bus inputs and pins on the falling edge, so every access is settled at the sampling edge. It samples read data one time unit after a falling edge or a rising edge, so the check never races the flops. The stimulus uses word-aligned offsets only and holds clk_en_i steady within each access.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    MODE_IN  = 2'b00,
    MODE_OUT = 2'b01,
    MODE_ALT = 2'b10,
    MODE_ANA = 2'b11
  } pin_mode_e;

  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_ODR  = 8'h0C;
  localparam logic [7:0] OFS_IDR  = 8'h14;
  localparam logic [7:0] OFS_BSR  = 8'h18;

  typedef struct packed {
    logic mode_we;
    logic odr_we;
    logic bsr_we;
    logic rd_mode;
    logic rd_odr;
    logic rd_idr;
  } dec_t;
endpackage

// File: rtl/gpio_bus_dec.sv
module gpio_bus_dec
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic wr, rd;
  assign wr = valid_i & write_i & en_i;
  assign rd = valid_i & ~write_i;

  always_comb begin
    dec_o         = '0;
    dec_o.mode_we = wr && (addr_i == ADDR_W'(OFS_MODE));
    dec_o.odr_we  = wr && (addr_i == ADDR_W'(OFS_ODR));
    dec_o.bsr_we  = wr && (addr_i == ADDR_W'(OFS_BSR));
    dec_o.rd_mode = rd && (addr_i == ADDR_W'(OFS_MODE));
    dec_o.rd_odr  = rd && (addr_i == ADDR_W'(OFS_ODR));
    dec_o.rd_idr  = rd && (addr_i == ADDR_W'(OFS_IDR));
  end
endmodule

// File: rtl/gpio_mode_reg.sv
module gpio_mode_reg
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  localparam int MODE_W  = 2 * NUM_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [NUM_PINS-1:0] oe_o
);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= wdata_i;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    pin_mode_e m;
    assign m       = pin_mode_e'(mode_q[2*p +: 2]);
    assign oe_o[p] = (m == MODE_OUT);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                odr_we_i,
  input  logic                bsr_we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_PINS-1:0] out_o
);
  logic [NUM_PINS-1:0] q, set_b, clr_b;

  assign set_b = wdata_i[NUM_PINS-1:0];
  assign clr_b = wdata_i[2*NUM_PINS-1:NUM_PINS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (odr_we_i) q <= set_b;
    else if (bsr_we_i) q <= (q & ~clr_b) | set_b;  // set wins
  end

  assign out_o = q;

  // R4, R6: set bits high after the write, even when the clear bit is also given
  a_r4_set_bits_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_we_i |=> ((out_o & $past(set_b)) == $past(set_b)));

  a_r5_clear_bits_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_we_i |=> ((out_o & ($past(clr_b) & ~$past(set_b))) == '0));

  a_r5_untouched_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_we_i |=> ((out_o & ~($past(clr_b) | $past(set_b))) ==
                  ($past(out_o) & ~($past(clr_b) | $past(set_b)))));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 16,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] sync_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], pin_i[p]};
    end
    assign sync_o[p] = sh_q[STAGES-1];
  end

  // assertion support: edges since reset, saturating
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd2)   age_q <= age_q + 2'd1;
  end

  a_r8_two_flop_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (sync_o == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clk_en_i,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  localparam int MODE_W = 2 * NUM_PINS;

  dec_t                dec;
  logic [MODE_W-1:0]   mode;
  logic [NUM_PINS-1:0] idr;

  gpio_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i (bus_valid_i),
    .write_i (bus_write_i),
    .en_i    (clk_en_i),
    .addr_i  (bus_addr_i),
    .dec_o   (dec)
  );

  gpio_mode_reg #(.NUM_PINS(NUM_PINS)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dec.mode_we),
    .wdata_i (bus_wdata_i[MODE_W-1:0]),
    .mode_o  (mode),
    .oe_o    (pin_oe_o)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .odr_we_i (dec.odr_we),
    .bsr_we_i (dec.bsr_we),
    .wdata_i  (bus_wdata_i),
    .out_o    (pin_out_o)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_in_i),
    .sync_o (idr)
  );

  // set/clear word and unmapped offsets fall to zero
  always_comb begin
    bus_rdata_o = '0;
    if (dec.rd_mode)     bus_rdata_o = DATA_W'(mode);
    else if (dec.rd_odr) bus_rdata_o = DATA_W'(pin_out_o);
    else if (dec.rd_idr) bus_rdata_o = DATA_W'(idr);
  end

  a_r7_gated_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(pin_out_o) && $stable(mode)));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    a_r2_oe_matches_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_valid_i && !bus_write_i && bus_addr_i == ADDR_W'(OFS_MODE)) |->
        (pin_oe_o[p] == (bus_rdata_o[2*p +: 2] == 2'b01)));
  end
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_mode = '0;
  logic [15:0] exp_out = '0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en),
    .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  function automatic logic [31:0] next_rnd(logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic [15:0] oe_of(logic [31:0] m);
    logic [15:0] r = '0;
    for (int p = 0; p < 16; p++) r[p] = (m[2*p +: 2] == 2'b01);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic check_state(string req);
    logic [31:0] d;
    rd(8'h00, d);  chk({req, " mode"}, d, exp_mode);
    rd(8'h0C, d);  chk({req, " odr"}, d, {16'h0, exp_out});
    chk({req, " pin_out"}, {16'h0, pin_out}, {16'h0, exp_out});
    chk({req, " oe"}, {16'h0, pin_oe}, {16'h0, oe_of(exp_mode)});
  endtask

  task automatic bsr(logic [31:0] d);
    wr(8'h18, d);
    exp_out = (exp_out & ~d[31:16]) | d[15:0];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);  // lets pin_in reach the synchronizer

    // R1 reset state
    check_state("R1");
    rd(8'h14, d); chk("R1 idr", d, 32'h0);

    // R2 every pin through every mode code
    for (int p = 0; p < 16; p++)
      for (int m = 0; m < 4; m++) begin
        exp_mode = 32'(m) << (2*p);
        wr(8'h00, exp_mode);
        rd(8'h00, d); chk("R2 mode readback", d, exp_mode);
        chk("R2 oe", {16'h0, pin_oe}, {16'h0, oe_of(exp_mode)});
      end
    for (int i = 0; i < 16; i++) begin
      rng = next_rnd(rng); exp_mode = rng;
      wr(8'h00, exp_mode);
      chk("R2 mixed oe", {16'h0, pin_oe}, {16'h0, oe_of(exp_mode)});
    end

    // R3 direct writes, upper bits dropped
    for (int i = 0; i < 8; i++) begin
      rng = next_rnd(rng);
      wr(8'h0C, rng); exp_out = rng[15:0];
      rd(8'h0C, d); chk("R3 odr readback", d, {16'h0, exp_out});
      chk("R3 pin_out", {16'h0, pin_out}, {16'h0, exp_out});
    end

    // R4 R5 R6 single-pin sweep
    wr(8'h0C, 32'h0); exp_out = '0;
    for (int p = 0; p < 16; p++) begin
      bsr(32'h1 << p);
      chk("R4 set one pin", {16'h0, pin_out}, {16'h0, exp_out});
      bsr(32'h1 << (p + 16));
      chk("R5 clear one pin", {16'h0, pin_out}, {16'h0, exp_out});
      bsr((32'h1 << p) | (32'h1 << (p + 16)));
      chk("R6 set wins", {16'h0, pin_out[p]}, 32'h1);
    end
    // R5 zero word leaves all pins
    d = {16'h0, exp_out};
    bsr(32'h0);
    chk("R5 zero word no change", {16'h0, pin_out}, d);
    for (int i = 0; i < 32; i++) begin
      rng = next_rnd(rng);
      bsr(rng);
      chk("R4/R5/R6 random set-clear", {16'h0, pin_out}, {16'h0, exp_out});
    end
    rd(8'h0C, d); chk("R3 odr after set-clear", d, {16'h0, exp_out});

    // R7 gated writes
    @(negedge clk); clk_en = 1'b0;
    wr(8'h00, ~exp_mode);
    wr(8'h0C, {16'h0, ~exp_out});
    wr(8'h18, {exp_out, ~exp_out});
    @(negedge clk); clk_en = 1'b1;
    check_state("R7");

    // R8 two-flop latency
    for (int i = 0; i < 6; i++) begin
      logic [15:0] old_v;
      rng = next_rnd(rng);
      old_v = pin_in;
      @(negedge clk);
      pin_in = rng[15:0] ^ 16'h8001;
      valid = 1'b1; write = 1'b0; addr = 8'h14;
      @(posedge clk); #1;
      chk("R8 not visible after 1 edge", rdata, {16'h0, old_v});
      @(posedge clk); #1;
      chk("R8 visible after 2 edges", rdata, {16'h0, pin_in});
      @(negedge clk); valid = 1'b0;
    end
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R8 idr write ignored", d, {16'h0, pin_in});
    check_state("R8 idr write no side effect");

    // R9 zero reads
    for (int a = 0; a < 64; a += 4) begin
      if (a != 8'h00 && a != 8'h0C && a != 8'h14) begin
        rd(8'(a), d); chk("R9 zero read", d, 32'h0);
      end
    end

    // R10 no read presented
    @(negedge clk); valid = 1'b0; addr = 8'h00; #1;
    chk("R10 idle rdata zero", rdata, 32'h0);
    valid = 1'b1; write = 1'b1; addr = 8'h0C; wdata = {16'h0, exp_out}; #1;
    chk("R10 write cycle rdata zero", rdata, 32'h0);
    @(negedge clk); valid = 1'b0; write = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule